// File: doc/BRIEF.md
# Parallel Addressable RGB LED String Driver

This block drives several chains of addressable RGB LEDs at the same time, with one serial data output per chain. Frame data arrives as bit-sliced words: each accepted word holds one bit for every lane, and bit k of the word belongs to lane k. The block turns each bit into a fixed-length pulse symbol whose high time tells a zero from a one. All lanes step through the same bit index together, so one word gives the current symbol for every chain at once.

Input words are loaded through a ready/valid stream into a two-bank frame store. One bank is played out while the other fills. The banks trade places only when the low reset gap after a frame ends. If the filling bank is not complete at that moment, the block raises a sticky underrun flag and keeps every line low until a full frame is available. A start-of-frame marker on the first word brings the write position back to zero. A one-cycle pulse marks the end of every reset gap.

Top module: `ledStripDriver`

## Requirements
- R1: After reset, every lane output is low, `inReady` is high, and `frameDone` and `underrun` are low.
- R2: Every symbol starts a new bit period of BIT_CYCLES clocks. A 0 bit keeps its lane high for T0H_CYCLES clocks and a 1 bit keeps it high for T1H_CYCLES clocks. The lane is low for the rest of the period.
- R3: A frame is PIXELS*24 words, played out in the order they were accepted. The host places pixel p of lane k so that word p*24+j, bit k, carries bit 23-j of the lane's 24-bit value {green, red, blue}, each colour sent most significant bit first.
- R4: All lanes start each symbol in the same clock cycle, because every symbol begins with all lane outputs high together.
- R5: After the last symbol of a frame, all lanes stay low for at least RESET_CYCLES clocks before the next symbol begins.
- R6: `frameDone` is high for exactly one cycle at the end of each reset gap. Each frame shown gives exactly one pulse.
- R7: While a frame is being shown, the other bank accepts the next frame. If that bank is full when the gap ends, the first symbol of the new frame starts exactly BIT_CYCLES+RESET_CYCLES clocks after the start of the previous frame's last symbol.
- R8: Once the loading bank is full, `inReady` is low and offered words are ignored until the banks swap at the end of a gap.
- R9: If the loading bank is not full when a gap ends, `underrun` goes high and stays high until reset. The lanes stay low until a full frame has been loaded, and that frame is then shown.
- R10: A word accepted with `inSof` high is written as word 0 of the frame. Any partial frame loaded before it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word is valid |
| inReady | output | 1 | Block can accept a word |
| inSof | input | 1 | Marks the first word of a frame |
| inData | input | LANES | One frame bit per lane, bit k for lane k |
| laneOut | output | LANES | Registered serial data output per LED chain |
| frameDone | output | 1 | One-cycle pulse when a reset gap ends |
| underrun | output | 1 | Sticky flag: next frame was not ready at the end of a gap |

## Verification
The assertions assume that the host never pulls `inReady` low. They also assume that `inReady` can only fall as the result of a word being written, so every drop in ready must follow a cycle with `inValid` high. The bench drives inputs one cycle at a time, shortly after each clock edge. It changes them only when it has seen `inReady` at the following sampling point, and it keeps `inValid` asserted while ready is low, to show that those words are dropped. Frames are timed so that one frame is still playing while the next is loaded. The bench then stops loading on purpose to force an underrun.

// File: rtl/ledDrvPkg.sv
package ledDrvPkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic highZero;  // a lane sending 0 should be high now
    logic highOne;   // a lane sending 1 should be high now
    logic swap;      // exchange playing and loading banks
  } ctrlStrobes_t;
endpackage

// File: rtl/ledDrvDatapath.sv
module ledDrvDatapath
  import ledDrvPkg::*;
#(
  parameter int LANES       = 4,
  parameter int FRAME_WORDS = 384,
  localparam int AW         = $clog2(FRAME_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic [LANES-1:0] inData,
  output logic             inReady,
  input  ctrlStrobes_t     strobes,
  input  logic [AW-1:0]    rdAddr,
  output logic             writeFull,
  output logic [LANES-1:0] laneOut
);
  localparam logic [AW-1:0] WORD_LAST = AW'(FRAME_WORDS - 1);

  logic [LANES-1:0] frameMem [2][FRAME_WORDS];
  logic             readBank;
  logic             wrBank;
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    wrAddr;
  logic             accept;
  logic [LANES-1:0] rdWord;

  assign inReady = !writeFull;
  assign accept  = inValid && !writeFull;
  assign wrAddr  = inSof ? '0 : wrPtr;
  assign wrBank  = ~readBank;
  assign rdWord  = frameMem[readBank][rdAddr];

  always_ff @(posedge clk) begin
    if (accept) frameMem[wrBank][wrAddr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      writeFull <= 1'b0;
      readBank  <= 1'b0;
    end else begin
      if (accept) begin
        if (wrAddr == WORD_LAST) begin
          wrPtr     <= '0;
          writeFull <= 1'b1;
        end else begin
          wrPtr <= wrAddr + 1'b1;
        end
      end
      if (strobes.swap) begin
        readBank  <= ~readBank;
        writeFull <= 1'b0;
      end
    end
  end

  // one output flop per lane so all edges line up
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) laneOut[k] <= 1'b0;
      else       laneOut[k] <= rdWord[k] ? strobes.highOne : strobes.highZero;
    end
  end
endmodule

// File: rtl/ledDrvControl.sv
module ledDrvControl
  import ledDrvPkg::*;
#(
  parameter int FRAME_WORDS  = 384,
  parameter int BIT_CYCLES   = 125,
  parameter int T0H_CYCLES   = 40,
  parameter int T1H_CYCLES   = 80,
  parameter int RESET_CYCLES = 5000,
  localparam int AW          = $clog2(FRAME_WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          writeFull,
  output ctrlStrobes_t  strobes,
  output logic [AW-1:0] rdAddr,
  output logic          frameDone,
  output logic          underrun
);
  localparam int CW = $clog2(BIT_CYCLES);
  localparam int GW = $clog2(RESET_CYCLES);
  localparam logic [AW-1:0] WORD_LAST = AW'(FRAME_WORDS - 1);
  localparam logic [CW-1:0] BIT_LAST  = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] T0H_C     = CW'(T0H_CYCLES);
  localparam logic [CW-1:0] T1H_C     = CW'(T1H_CYCLES);
  localparam logic [GW-1:0] GAP_LAST  = GW'(RESET_CYCLES - 1);

  typedef enum logic [1:0] {WAIT_FULL, SEND_BITS, HOLD_GAP} phase_t;

  phase_t        phase;
  logic [CW-1:0] cycleCnt;
  logic [AW-1:0] bitIdx;
  logic [GW-1:0] gapCnt;
  logic          gapEnd;

  assign gapEnd = (phase == HOLD_GAP) && (gapCnt == GAP_LAST);

  always_comb begin
    strobes.swap     = writeFull && ((phase == WAIT_FULL) || gapEnd);
    strobes.highZero = (phase == SEND_BITS) && (cycleCnt < T0H_C);
    strobes.highOne  = (phase == SEND_BITS) && (cycleCnt < T1H_C);
  end
  assign rdAddr = bitIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= WAIT_FULL;
      cycleCnt  <= '0;
      bitIdx    <= '0;
      gapCnt    <= '0;
      frameDone <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      unique case (phase)
        WAIT_FULL: begin
          if (writeFull) begin
            phase    <= SEND_BITS;
            cycleCnt <= '0;
            bitIdx   <= '0;
          end
        end
        SEND_BITS: begin
          if (cycleCnt == BIT_LAST) begin
            cycleCnt <= '0;
            if (bitIdx == WORD_LAST) begin
              phase  <= HOLD_GAP;
              gapCnt <= '0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            cycleCnt <= cycleCnt + 1'b1;
          end
        end
        HOLD_GAP: begin
          if (gapEnd) begin
            frameDone <= 1'b1;
            if (writeFull) begin
              phase    <= SEND_BITS;
              cycleCnt <= '0;
              bitIdx   <= '0;
            end else begin
              underrun <= 1'b1;
              phase    <= WAIT_FULL;
            end
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: phase <= WAIT_FULL;
      endcase
    end
  end
endmodule

// File: rtl/ledStripDriver.sv
module ledStripDriver
  import ledDrvPkg::*;
#(
  parameter int LANES        = 4,
  parameter int PIXELS       = 16,
  parameter int BIT_CYCLES   = 125,
  parameter int T0H_CYCLES   = 40,
  parameter int T1H_CYCLES   = 80,
  parameter int RESET_CYCLES = 5000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inSof,
  input  logic [LANES-1:0] inData,
  output logic [LANES-1:0] laneOut,
  output logic             frameDone,
  output logic             underrun
);
  localparam int FRAME_WORDS = PIXELS * 24;
  localparam int AW          = $clog2(FRAME_WORDS);

  ctrlStrobes_t  strobes;
  logic [AW-1:0] rdAddr;
  logic          writeFull;

  ledDrvControl #(
    .FRAME_WORDS (FRAME_WORDS),
    .BIT_CYCLES  (BIT_CYCLES),
    .T0H_CYCLES  (T0H_CYCLES),
    .T1H_CYCLES  (T1H_CYCLES),
    .RESET_CYCLES(RESET_CYCLES)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .writeFull(writeFull),
    .strobes  (strobes),
    .rdAddr   (rdAddr),
    .frameDone(frameDone),
    .underrun (underrun)
  );

  ledDrvDatapath #(
    .LANES      (LANES),
    .FRAME_WORDS(FRAME_WORDS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSof    (inSof),
    .inData   (inData),
    .inReady  (inReady),
    .strobes  (strobes),
    .rdAddr   (rdAddr),
    .writeFull(writeFull),
    .laneOut  (laneOut)
  );
endmodule

// File: rtl/ledStripDriverChecker.sv
module ledStripDriverChecker #(
  parameter int LANES      = 4,
  parameter int T1H_CYCLES = 80
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic [LANES-1:0] laneOut,
  input logic             frameDone,
  input logic             underrun
);
  int highRun;

  always_ff @(posedge clk) begin
    if (!rstN)               highRun <= 0;
    else if (laneOut != '0)  highRun <= highRun + 1;
    else                     highRun <= 0;
  end

  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    highRun <= T1H_CYCLES); // R2

  AST_LANES_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (laneOut != '0 && $past(laneOut) == '0) |-> laneOut == '1); // R4

  AST_GAP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> laneOut == '0); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone); // R6

  AST_READY_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inReady) |-> $past(inValid)); // R8

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun); // R9
endmodule

bind ledStripDriver ledStripDriverChecker #(
  .LANES     (LANES),
  .T1H_CYCLES(T1H_CYCLES)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .laneOut  (laneOut),
  .frameDone(frameDone),
  .underrun (underrun)
);

// File: tb/test_ledStripDriver.sv
module test_ledStripDriver;
  localparam int LANES  = 4;
  localparam int PIXELS = 2;
  localparam int BITC   = 10;
  localparam int T0H    = 3;
  localparam int T1H    = 6;
  localparam int RSTC   = 20;
  localparam int FW     = PIXELS * 24;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic             inSof = 1'b0;
  logic [LANES-1:0] inData = '0;
  logic [LANES-1:0] laneOut;
  logic             frameDone;
  logic             underrun;

  always #2 clk = ~clk; // 250 MHz

  ledStripDriver #(
    .LANES(LANES), .PIXELS(PIXELS), .BIT_CYCLES(BITC),
    .T0H_CYCLES(T0H), .T1H_CYCLES(T1H), .RESET_CYCLES(RSTC)
  ) i_ledStripDriver (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inSof(inSof), .inData(inData), .laneOut(laneOut),
    .frameDone(frameDone), .underrun(underrun)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // ---------------- output monitor ----------------
  int               cyc = 0;
  logic [LANES-1:0] prevOut = '0;
  int               highCnt [LANES];
  logic [LANES-1:0] rxWords [0:255];
  int               startCyc [0:255];
  int               rxCount = 0;
  int               widthErr = 0;
  int               alignErr = 0;
  int               doneCount = 0;
  int               doneWideErr = 0;
  logic             prevDone = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (frameDone) doneCount <= doneCount + 1;
      if (frameDone && prevDone) doneWideErr <= doneWideErr + 1;
      prevDone <= frameDone;
      if (laneOut != '0 && prevOut == '0) begin
        if (laneOut != '1) alignErr <= alignErr + 1;
        if (rxCount < 256) startCyc[rxCount] <= cyc;
        for (int k = 0; k < LANES; k++) highCnt[k] = 0;
      end
      for (int k = 0; k < LANES; k++) if (laneOut[k]) highCnt[k] = highCnt[k] + 1;
      if (laneOut == '0 && prevOut != '0) begin
        logic [LANES-1:0] w;
        for (int k = 0; k < LANES; k++) begin
          w[k] = (highCnt[k] == T1H);
          if (highCnt[k] != T0H && highCnt[k] != T1H) widthErr <= widthErr + 1;
        end
        if (rxCount < 256) rxWords[rxCount] <= w;
        rxCount <= rxCount + 1;
      end
      prevOut <= laneOut;
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [23:0] colourOf(int fid, int p, int k);
    logic [7:0] g, r, b;
    g = 8'(fid * 37 + p * 11 + k * 5 + 1);
    r = 8'(fid * 91 + p * 3 + k);
    b = ~8'(fid + p * 7 + k * 13);
    return {g, r, b};
  endfunction

  function automatic logic [LANES-1:0] wordOf(int fid, int i);
    logic [LANES-1:0] w;
    logic [23:0] c;
    for (int k = 0; k < LANES; k++) begin
      c = colourOf(fid, i / 24, k);
      w[k] = c[23 - (i % 24)];
    end
    return w;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic pushWord(logic [LANES-1:0] d, logic sof);
    inValid = 1'b1; inData = d; inSof = sof;
    forever begin
      @(negedge clk);
      if (inReady) begin
        @(posedge clk); #1;
        break;
      end
    end
    inValid = 1'b0; inSof = 1'b0;
  endtask

  task automatic loadFrame(int fid);
    for (int i = 0; i < FW; i++) pushWord(wordOf(fid, i), i == 0);
  endtask

  task automatic checkFrame(string req, int fid, int base);
    int bad = 0;
    checks++;
    for (int p = 0; p < PIXELS; p++)
      for (int k = 0; k < LANES; k++) begin
        logic [23:0] got;
        for (int j = 0; j < 24; j++) got[23 - j] = rxWords[base + p * 24 + j][k];
        if (got != colourOf(fid, p, k) && bad == 0) begin
          bad = 1;
          $display("FAIL %s: frame %0d pixel %0d lane %0d actual %06h expected %06h",
                   req, fid, p, k, got, colourOf(fid, p, k));
        end
      end
    if (bad != 0) fails++;
  endtask

  task automatic waitRx(int n);
    while (rxCount < n) @(negedge clk);
  endtask

  task automatic waitDone(int n);
    while (doneCount < n) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    @(negedge clk);
    check("R1 laneOut", int'(laneOut), 0);
    check("R1 inReady", int'(inReady), 1);
    check("R1 frameDone", int'(frameDone), 0);
    check("R1 underrun", int'(underrun), 0);
  endtask

  task automatic testPingPong();
    int perBad = 0;
    loadFrame(1);
    loadFrame(2);
    @(negedge clk);
    check("R8 inReady low with loading bank full", int'(inReady), 0);
    // offer junk while not ready: must be ignored
    inValid = 1'b1; inData = 4'hA; inSof = 1'b1;
    repeat (10) @(posedge clk);
    #1 inValid = 1'b0; inSof = 1'b0;
    waitRx(2 * FW);
    checkFrame("R3 first frame contents", 1, 0);
    checkFrame("R8 second frame unchanged by ignored words", 2, FW);
    check("R2 symbol high widths", widthErr, 0);
    for (int i = 0; i < FW - 1; i++)
      if (startCyc[i + 1] - startCyc[i] != BITC) perBad++;
    check("R2 bit period", perBad, 0);
    check("R4 lanes aligned", alignErr, 0);
    check("R7 back-to-back frame spacing", startCyc[FW] - startCyc[FW - 1], BITC + RSTC);
    check("R5 low gap at least reset length",
          int'((startCyc[FW] - startCyc[FW - 1] - T1H) >= RSTC), 1);
  endtask

  task automatic testUnderrun();
    waitDone(2);
    check("R9 underrun set at gap end", int'(underrun), 1);
    check("R9 lines low on underrun", int'(laneOut), 0);
    repeat (100) @(negedge clk);
    check("R9 no symbols while starved", rxCount, 2 * FW);
    check("R9 lines still low", int'(laneOut), 0);
  endtask

  task automatic testSofRestart();
    for (int i = 0; i < 5; i++) pushWord(4'(i + 5), i == 0);
    loadFrame(3);
    waitRx(3 * FW);
    checkFrame("R10 frame after restart marker", 3, 2 * FW);
    check("R9 underrun stays set", int'(underrun), 1);
    waitDone(3);
    @(negedge clk);
    check("R6 one done pulse per frame", doneCount, 3);
    check("R6 done pulse single cycle", doneWideErr, 0);
    check("R2 widths after restart", widthErr, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testPingPong();
    testUnderrun();
    testSofRestart();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule